// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a 16-bit position count from a two-channel incremental encoder. Each phase input passes through a two-flop synchroniser and a stability filter. The filter accepts a new level only after a run of equal samples. The filtered pair {A,B} drives a four-state Gray-code machine. That machine reports which phase moved, the direction of the step, and any illegal jump in which both phases change together. A 3-bit edge-select field chooses which phase transitions count. A 3-bit mode field turns incremental counting on or off, and an enable bit chooses between direction taken from the phases and fixed up-counting.

Software uses a small write port. Address 0 is the control word: bits [2:0] hold the mode, bits [6:4] hold the edge select, and bit 8 is the automatic-direction enable. Address 1 loads the count. The count, the last direction, an invalid-select flag and a sticky jump-error flag are brought out as ports. A zero-marker input is synchronised and filtered with a run length of one sample. While it is high, it clears the count.

The phase machine has the states PH_00, PH_10, PH_11 and PH_01, named after the filtered {A,B} levels. From each state the block takes one of four transitions. STAY keeps the same pair. FWD moves one step along 00→10→11→01→00, which means A leads. BACK moves one step the other way, which means B leads. JUMP moves to the diagonal state. The counter applies one action each cycle, in this priority order: ACT_CLEAR (zero marker), ACT_LOAD (count write), ACT_INC or ACT_DEC (a qualified step), and ACT_HOLD.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, dir_up_o is 1, edge_sel_bad_o and jump_err_o are 0, and the mode field is 000, so nothing counts.
- R2: Counting happens only while the mode field (control bits [2:0]) is 110 or 111. With any other mode, phase steps leave the count unchanged.
- R3: With edge select 011, each single-phase transition of A or B moves the count by one. A full quadrature cycle therefore changes it by 4.
- R4: With edge select 001, only transitions of phase A count (2 per full cycle). Transitions of phase B are ignored.
- R5: With edge select 010, only transitions of phase B count (2 per full cycle). Transitions of phase A are ignored.
- R6: Edge select 000 counts nothing. Edge select 1xx also counts nothing and sets edge_sel_bad_o to 1 for as long as it is selected.
- R7: With automatic direction enabled (control bit 8 = 1), the count goes up when A leads B (00→10→11→01→00) and down when B leads A. dir_up_o shows the direction of the last counted step, with 1 meaning up.
- R8: With automatic direction disabled, every qualified step counts up whatever the phase order, and dir_up_o reads 1.
- R9: If both filtered phases change in the same sample, the count does not change, and jump_err_o goes to 1 and stays there until reset.
- R10: A phase level that lasts fewer than FILT_LEN consecutive samples is ignored and produces no count.
- R11: The count wraps modulo 2^16, so counting up from 0xFFFF gives 0x0000.
- R12: A write to address 1 loads the count. If a count step falls in the same cycle, the written value wins.
- R13: While the synchronised zero marker is high, the count is forced to 0, and this overrides a count write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a_i | input | 1 | Encoder phase A (asynchronous) |
| phase_b_i | input | 1 | Encoder phase B (asynchronous) |
| zero_mark_i | input | 1 | Zero-position marker; high clears the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = control word, 1 = count |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Position count |
| dir_up_o | output | 1 | Direction of last counted step (1 = up) |
| edge_sel_bad_o | output | 1 | Reserved edge select (1xx) in use |
| jump_err_o | output | 1 | Sticky illegal two-phase jump flag |

## Verification
The assertions assume that the phase inputs behave like a real encoder. Each level is held for well over FILT_LEN plus the synchroniser depth, so any jump the filter sees comes from an intentional simultaneous change. They also assume that writes and the zero marker are stable across clock edges. The bench changes every input only on falling clock edges and holds each phase level for ten cycles. The exception is the planned glitch, which lasts one cycle. The only other deliberate violation is the simultaneous change of both phases, used to trigger the jump error. The same-cycle priority cases are placed by counting the fixed latency: two synchroniser flops, the filter history and the filter output register.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Filtered phase pair, bit 1 = A, bit 0 = B
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_t;

    // Transition taken by the phase machine in one sample
    typedef enum logic [1:0] {
        TR_STAY = 2'd0,
        TR_FWD  = 2'd1,
        TR_BACK = 2'd2,
        TR_JUMP = 2'd3
    } trans_t;

    // Counter action chosen each cycle
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_INC   = 3'd3,
        ACT_DEC   = 3'd4
    } act_t;

    // Edge-select codes
    localparam logic [2:0] SEL_NONE = 3'b000;
    localparam logic [2:0] SEL_A    = 3'b001;
    localparam logic [2:0] SEL_B    = 3'b010;
    localparam logic [2:0] SEL_AB   = 3'b011;

    // Control word field positions
    localparam int MODE_LSB = 0;
    localparam int SEL_LSB  = 4;
    localparam int AUTO_BIT = 8;

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] sel;
        logic       auto_dir;
    } ctl_t;

endpackage

// File: rtl/qenc_inflt.sv
// Synchroniser followed by a run-length stability filter for one input.
module qenc_inflt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    generate
        if (FILT_LEN == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= sync_q[SYNC_STAGES-1];
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
        end else if (&hist_q) begin
            filt_q <= 1'b1;
        end else if (~|hist_q) begin
            filt_q <= 1'b0;
        end
    end

    assign dout = filt_q;

endmodule

// File: rtl/qenc_phase_fsm.sv
// Four-state Gray-code machine over the filtered phase pair.
module qenc_phase_fsm
    import qenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_f,
    input  logic b_f,
    output logic a_moved,
    output logic b_moved,
    output logic step_up,
    output logic step_valid,
    output logic jump,
    output logic jump_err_o
);
    phase_t state_q;
    phase_t obs;
    phase_t fwd_nxt;
    phase_t back_nxt;
    trans_t trans;
    logic   jerr_q;

    assign obs = phase_t'({a_f, b_f});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= obs;
    end

    // Neighbour table and transition classification
    always_comb begin
        fwd_nxt  = PH_00;
        back_nxt = PH_00;
        unique case (state_q)
            PH_00: begin fwd_nxt = PH_10; back_nxt = PH_01; end
            PH_10: begin fwd_nxt = PH_11; back_nxt = PH_00; end
            PH_11: begin fwd_nxt = PH_01; back_nxt = PH_10; end
            PH_01: begin fwd_nxt = PH_00; back_nxt = PH_11; end
            default: begin fwd_nxt = PH_00; back_nxt = PH_00; end
        endcase
        if (obs == state_q)       trans = TR_STAY;
        else if (obs == fwd_nxt)  trans = TR_FWD;
        else if (obs == back_nxt) trans = TR_BACK;
        else                      trans = TR_JUMP;
    end

    // Outputs
    always_comb begin
        step_valid = 1'b0;
        step_up    = 1'b0;
        jump       = 1'b0;
        unique case (trans)
            TR_STAY: ;
            TR_FWD:  begin step_valid = 1'b1; step_up = 1'b1; end
            TR_BACK: begin step_valid = 1'b1; step_up = 1'b0; end
            TR_JUMP: jump = 1'b1;
            default: ;
        endcase
        a_moved = step_valid & (obs[1] != state_q[1]);
        b_moved = step_valid & (obs[0] != state_q[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    jerr_q <= 1'b0;
        else if (jump) jerr_q <= 1'b1;
    end

    assign jump_err_o = jerr_q;

endmodule

// File: rtl/qenc_core.sv
// Control register, edge-select gating and position counter.
module qenc_core
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             a_moved,
    input  logic             b_moved,
    input  logic             step_up,
    input  logic             zero_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_up_o,
    output logic             sel_bad_o,
    output logic             mode_on,
    output logic             load,
    output logic             cnt_step,
    output logic             auto_on
);
    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             sel_a;
    logic             sel_b;
    logic             eff_up;
    act_t             act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && !wr_addr) begin
            ctl_q.mode     <= wr_data[MODE_LSB +: 3];
            ctl_q.sel      <= wr_data[SEL_LSB +: 3];
            ctl_q.auto_dir <= wr_data[AUTO_BIT];
        end
    end

    assign mode_on = (ctl_q.mode[2:1] == 2'b11);
    assign auto_on = ctl_q.auto_dir;

    always_comb begin
        sel_a = 1'b0;
        sel_b = 1'b0;
        unique case (ctl_q.sel)
            SEL_A:    sel_a = 1'b1;
            SEL_B:    sel_b = 1'b1;
            SEL_AB:   begin sel_a = 1'b1; sel_b = 1'b1; end
            default:  ;
        endcase
    end

    assign cnt_step  = mode_on & ((a_moved & sel_a) | (b_moved & sel_b));
    assign eff_up    = auto_on ? step_up : 1'b1;
    assign load      = wr_en & wr_addr;
    assign sel_bad_o = ctl_q.sel[2];

    always_comb begin
        if (zero_clr)      act = ACT_CLEAR;
        else if (load)     act = ACT_LOAD;
        else if (cnt_step) act = eff_up ? ACT_INC : ACT_DEC;
        else               act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: cnt_q <= '0;
                ACT_LOAD:  cnt_q <= wr_data;
                ACT_INC:   cnt_q <= cnt_q + 1'b1;
                ACT_DEC:   cnt_q <= cnt_q - 1'b1;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dir_q <= 1'b1;
        else if (!auto_on) dir_q <= 1'b1;
        else if (cnt_step) dir_q <= step_up;
    end

    assign count_o  = cnt_q;
    assign dir_up_o = dir_q;

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a_i,
    input  logic             phase_b_i,
    input  logic             zero_mark_i,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_up_o,
    output logic             edge_sel_bad_o,
    output logic             jump_err_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_ph;
    logic [NCH-1:0] flt_ph;
    logic           zero_clr;
    logic           a_moved;
    logic           b_moved;
    logic           step_up;
    logic           step_valid;
    logic           jump;
    logic           mode_on;
    logic           load;
    logic           cnt_step;
    logic           auto_on;

    assign raw_ph = {phase_a_i, phase_b_i};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ph
            qenc_inflt #(
                .SYNC_STAGES(SYNC_STAGES),
                .FILT_LEN   (FILT_LEN)
            ) u_flt (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_ph[c]),
                .dout (flt_ph[c])
            );
        end
    endgenerate

    qenc_inflt #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (1)
    ) u_zero (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (zero_mark_i),
        .dout (zero_clr)
    );

    qenc_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_f       (flt_ph[1]),
        .b_f       (flt_ph[0]),
        .a_moved   (a_moved),
        .b_moved   (b_moved),
        .step_up   (step_up),
        .step_valid(step_valid),
        .jump      (jump),
        .jump_err_o(jump_err_o)
    );

    qenc_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .a_moved  (a_moved),
        .b_moved  (b_moved),
        .step_up  (step_up),
        .zero_clr (zero_clr),
        .count_o  (count_o),
        .dir_up_o (dir_up_o),
        .sel_bad_o(edge_sel_bad_o),
        .mode_on  (mode_on),
        .load     (load),
        .cnt_step (cnt_step),
        .auto_on  (auto_on)
    );

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_o,
    input logic             dir_up_o,
    input logic             edge_sel_bad_o,
    input logic             jump_err_o,
    input logic [CNT_W-1:0] wr_data_i,
    input logic             zero_clr,
    input logic             load,
    input logic             cnt_step,
    input logic             mode_on,
    input logic             auto_on,
    input logic             jump,
    input logic             step_up
);
    // R13
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_clr |=> (count_o == '0));

    // R12
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !zero_clr) |=> (count_o == $past(wr_data_i)));

    // R9
    jump_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_err_o |=> jump_err_o);

    // R9
    jump_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump && !load && !zero_clr) |=> $stable(count_o));

    // R6
    bad_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_bad_o && !load && !zero_clr) |=> $stable(count_o));

    // R2
    mode_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_on && !load && !zero_clr) |=> $stable(count_o));

    // R11
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && (step_up || !auto_on) && (&count_o) && !load && !zero_clr)
        |=> (count_o == '0));

    // R8
    fixed_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_on |=> dir_up_o);

endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .count_o       (count_o),
    .dir_up_o      (dir_up_o),
    .edge_sel_bad_o(edge_sel_bad_o),
    .jump_err_o    (jump_err_o),
    .wr_data_i     (wr_data_i),
    .zero_clr      (zero_clr),
    .load          (load),
    .cnt_step      (cnt_step),
    .mode_on       (mode_on),
    .auto_on       (auto_on),
    .jump          (jump),
    .step_up       (step_up)
);

// File: tb/sim_qenc_counter.sv
`timescale 1ns/1ps
module sim_qenc_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pa = 1'b0;
    logic        pb = 1'b0;
    logic        zm = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        dir_up;
    logic        sel_bad;
    logic        jerr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] cnt;
        logic        dir;
        logic        bad;
        logic        jerr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    qenc_counter u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_a_i     (pa),
        .phase_b_i     (pb),
        .zero_mark_i   (zm),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .count_o       (count),
        .dir_up_o      (dir_up),
        .edge_sel_bad_o(sel_bad),
        .jump_err_o    (jerr)
    );

    function automatic logic [15:0] ctl(input logic [2:0] m, input logic [2:0] s, input logic a);
        return {7'b0, a, 1'b0, s, 1'b0, m};
    endfunction

    task automatic expect_state(input logic [15:0] c, input logic d, input logic b,
                                input logic j, input string tag);
        exp_t e;
        e.cnt = c; e.dir = d; e.bad = b; e.jerr = j; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic adr, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = adr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ph(input logic a, input logic b);
        @(negedge clk);
        pa = a; pb = b;
        repeat (10) @(negedge clk);
    endtask

    task automatic fwd_cycle;   // from 00, A leads
        set_ph(1, 0); set_ph(1, 1); set_ph(0, 1); set_ph(0, 0);
    endtask

    task automatic back_cycle;  // from 00, B leads
        set_ph(0, 1); set_ph(1, 1); set_ph(1, 0); set_ph(0, 0);
    endtask

    // Monitor: pop expected items and compare against the ports
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            checks++;
            if (count !== e.cnt || dir_up !== e.dir || sel_bad !== e.bad || jerr !== e.jerr) begin
                errors++;
                $display("FAIL %s: actual cnt=%h dir=%b bad=%b jerr=%b expected cnt=%h dir=%b bad=%b jerr=%b",
                         e.tag, count, dir_up, sel_bad, jerr, e.cnt, e.dir, e.bad, e.jerr);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state(16'h0000, 1, 0, 0, "R1 reset state");

        // R2: mode 000 with select 011 holds
        reg_wr(0, ctl(3'b000, 3'b011, 1));
        fwd_cycle();
        expect_state(16'h0000, 1, 0, 0, "R2 mode off holds");

        // R3 / R7: x4 counting up, then down
        reg_wr(0, ctl(3'b110, 3'b011, 1));
        fwd_cycle();
        expect_state(16'h0004, 1, 0, 0, "R3 x4 forward");
        back_cycle();
        expect_state(16'h0000, 0, 0, 0, "R7 B leads counts down");

        // R4: phase A only
        reg_wr(0, ctl(3'b110, 3'b001, 1));
        fwd_cycle();
        expect_state(16'h0002, 1, 0, 0, "R4 A edges only");

        // R5: phase B only
        reg_wr(0, ctl(3'b110, 3'b010, 1));
        fwd_cycle();
        expect_state(16'h0004, 1, 0, 0, "R5 B edges only");

        // R6: none and reserved
        reg_wr(0, ctl(3'b110, 3'b000, 1));
        fwd_cycle();
        expect_state(16'h0004, 1, 0, 0, "R6 select 000 holds");
        reg_wr(0, ctl(3'b110, 3'b100, 1));
        fwd_cycle();
        expect_state(16'h0004, 1, 1, 0, "R6 reserved select flagged");

        // R8: automatic direction off, B leads still counts up
        reg_wr(0, ctl(3'b111, 3'b011, 0));
        back_cycle();
        expect_state(16'h0008, 1, 0, 0, "R8 fixed up direction");

        // R10: one-sample glitch on A is filtered out
        reg_wr(0, ctl(3'b111, 3'b011, 1));
        @(negedge clk); pa = 1'b1;
        @(negedge clk); pa = 1'b0;
        repeat (10) @(negedge clk);
        expect_state(16'h0008, 1, 0, 0, "R10 glitch ignored");

        // R11: wrap from FFFF
        reg_wr(1, 16'hFFFF);
        expect_state(16'hFFFF, 1, 0, 0, "R12 count write");
        set_ph(1, 0);
        expect_state(16'h0000, 1, 0, 0, "R11 wrap to zero");

        // R12: write lands in the same cycle as a step (10 -> 11)
        @(negedge clk); pb = 1'b1;
        repeat (5) @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'h1234;
        @(negedge clk); wr_en = 1'b0;
        repeat (8) @(negedge clk);
        expect_state(16'h1234, 1, 0, 0, "R12 write beats step");

        // R13: zero marker overrides a write
        @(negedge clk); zm = 1'b1;
        repeat (6) @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'h5555;
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk); zm = 1'b0;
        repeat (8) @(negedge clk);
        expect_state(16'h0000, 1, 0, 0, "R13 zero beats write");

        // R9: 11 -> 00 in one sample
        set_ph(0, 0);
        expect_state(16'h0000, 1, 0, 1, "R9 jump no count");
        set_ph(1, 0);
        expect_state(16'h0001, 1, 0, 1, "R9 flag sticky");

        repeat (4) @(negedge clk);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule